// File: doc/BRIEF.md
# Look-ahead Feedback Shift Register over GF(2^31-1)

This block holds sixteen 31-bit cells that step once per clock as a word-wide shift register. The new top cell is a weighted sum of five earlier cells, taken modulo the prime p = 2^31-1. Each weight is a power of two, so each product is a 31-bit left rotation. Each sum is a two-operand adder with end-around carry. A stream generator built around the register reads the cells every cycle and builds one 32-bit output word per step.

The full sum needs a chain of six modular additions. That chain is too deep for one cycle, so the block splits it. Four of the five weighted cells for the next step are already present in the current state, one position higher. Their partial sum is formed one cycle early and held in a register. In the cycle the new value is needed, only the newest cell and the optional initialization word are added to that partial sum. Because of this, the pipeline does not change the sequence of states.

In initialization mode, an external 32-bit word W is mixed in. It is combined as u = (W xor X3) >> 1, where X3 is the low half of cell 2 followed by the high half of cell 0. After a load, the block spends one priming cycle and then steps on every clock.

Top module: `zlf_feedback_pipe`

## Requirements
- R1: While reset is high, and after reset until the first load, every cell reads zero, `valid_o` is low, and the cells do not change.
- R2: A high `load_i` at a clock edge writes cell i from bits [31i+30:31i] of `cells_init_i`. A load overrides any step that would have happened at that edge.
- R3: With `init_mode_i` = 0 (working mode), each step moves cell i+1 into cell i for i = 0..14. The new cell 15 is (2^15·s15 + 2^17·s13 + 2^21·s10 + 2^20·s4 + 257·s0) mod p.
- R4: With `init_mode_i` = 1 (initialization mode), u = (`w_i` xor X3) >> 1 is added to that sum modulo p. X3 = {s2[15:0], s0[30:15]}, and `w_i` and the mode are sampled at the stepping edge.
- R5: A new cell value whose residue is zero is stored as 2^31-1, never as 0.
- R6: After a load at edge k, `valid_o` is low until edge k+1 and high from edge k+1 until the next load. The first step happens at edge k+2, and one step follows on every later edge.
- R7: A cell holding 2^31-1 acts as an operand congruent to zero, both in the rotations and in the sums.
- R8: `init_mode_i` and `w_i` have no effect while the block is idle or priming: the cells do not change in those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Load the cells and start priming |
| init_mode_i | input | 1 | 1 = initialization mode, 0 = working mode |
| w_i | input | 32 | Word mixed in during initialization steps |
| cells_init_i | input | 496 | Values to load; cell i at bits [31i+30:31i] |
| cells_o | output | 496 | Current cells, same packing as the load bus |
| valid_o | output | 1 | High once priming is done; the cells step on every edge |

## Verification
Every cell appears on `cells_o`, so a wrong sum shows up in cell 15 in the cycle right after the faulty step. A stale or misaligned partial sum makes cell 15 diverge one cycle after the step that used it. Such an error then walks down to cell 0 over the next fifteen steps and corrupts every later value. A wrong priming or load sequence shows at once as a `valid_o` mismatch, or as a whole state that is one step early or late.

// File: rtl/zlf_pkg.sv
package zlf_pkg;
    localparam int CW = 31;
    localparam int NC = 16;
    localparam int WW = 32;
    localparam int HALF = 16;

    typedef logic [CW-1:0] cell_t;
    typedef logic [NC-1:0][CW-1:0] cell_vec_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FILL = 2'd1,
        PH_RUN  = 2'd2
    } phase_e;

    localparam cell_t PRIME = '1;

    // 2^k * x mod (2^31-1) as a left rotation
    function automatic cell_t rotl(cell_t x, int unsigned k);
        logic [2*CW-1:0] d;
        d = {x, x} << k;
        return d[2*CW-1:CW];
    endfunction

    // u = (W xor X3) >> 1, X3 = s2 low half followed by s0 high half
    function automatic cell_t mix_word(logic [WW-1:0] w, cell_t s2, cell_t s0);
        logic [WW-1:0] x3;
        logic [WW-1:0] t;
        x3 = {s2[HALF-1:0], s0[CW-1:CW-HALF]};
        t  = w ^ x3;
        return t[WW-1:1];
    endfunction
endpackage

// File: rtl/zlf_modadd.sv
module zlf_modadd
    import zlf_pkg::*;
(
    input  cell_t a,
    input  cell_t b,
    output cell_t y
);
    logic [CW:0] s;

    assign s = {1'b0, a} + {1'b0, b};
    assign y = s[CW-1:0] + cell_t'(s[CW]);
endmodule

// File: rtl/zlf_lookahead.sv
module zlf_lookahead
    import zlf_pkg::*;
(
    input  cell_t c13,
    input  cell_t c10,
    input  cell_t c4,
    input  cell_t c0,
    output cell_t part
);
    localparam int NT = 5;
    localparam int unsigned ROT [NT] = '{17, 21, 20, 0, 8};

    cell_t src  [NT];
    cell_t term [NT];
    cell_t lvl1 [2];
    cell_t lvl2;

    assign src[0] = c13;
    assign src[1] = c10;
    assign src[2] = c4;
    assign src[3] = c0;
    assign src[4] = c0;

    for (genvar i = 0; i < NT; i++) begin : g_term
        assign term[i] = rotl(src[i], ROT[i]);
    end

    for (genvar j = 0; j < 2; j++) begin : g_lvl1
        zlf_modadd u_add (.a(term[2*j]), .b(term[2*j+1]), .y(lvl1[j]));
    end

    zlf_modadd u_add2 (.a(lvl1[0]), .b(lvl1[1]), .y(lvl2));
    zlf_modadd u_add3 (.a(lvl2), .b(term[NT-1]), .y(part));
endmodule

// File: rtl/zlf_tail.sv
module zlf_tail
    import zlf_pkg::*;
(
    input  cell_t          part,
    input  cell_t          s15,
    input  cell_t          s2,
    input  cell_t          s0,
    input  logic [WW-1:0]  w,
    input  logic           init_en,
    output cell_t          fb
);
    localparam int unsigned TOP_ROT = 15;

    cell_t u;
    cell_t sum1;
    cell_t sum2;

    assign u = init_en ? mix_word(w, s2, s0) : '0;

    zlf_modadd u_top (.a(part), .b(rotl(s15, TOP_ROT)), .y(sum1));
    zlf_modadd u_mix (.a(sum1), .b(u), .y(sum2));

    assign fb = (sum2 == '0) ? PRIME : sum2;
endmodule

// File: rtl/zlf_feedback_pipe.sv
module zlf_feedback_pipe
    import zlf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              init_mode_i,
    input  logic [WW-1:0]     w_i,
    input  logic [NC*CW-1:0]  cells_init_i,
    output logic [NC*CW-1:0]  cells_o,
    output logic              valid_o
);
    localparam int NTAP = 4;
    localparam int TAP [NTAP] = '{13, 10, 4, 0};

    cell_vec_t cells_q;
    cell_t     part_q;
    phase_e    phase_q;
    cell_t     la_in [NTAP];
    cell_t     la_out;
    cell_t     fb;
    logic      run;

    assign run = (phase_q == PH_RUN);

    // Look-ahead: when stepping, the taps of the next state sit one cell higher
    for (genvar t = 0; t < NTAP; t++) begin : g_tap
        assign la_in[t] = run ? cells_q[TAP[t]+1] : cells_q[TAP[t]];
    end

    zlf_lookahead u_la (
        .c13 (la_in[0]),
        .c10 (la_in[1]),
        .c4  (la_in[2]),
        .c0  (la_in[3]),
        .part(la_out)
    );

    zlf_tail u_tail (
        .part   (part_q),
        .s15    (cells_q[NC-1]),
        .s2     (cells_q[2]),
        .s0     (cells_q[0]),
        .w      (w_i),
        .init_en(init_mode_i),
        .fb     (fb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cells_q <= '0;
            part_q  <= '0;
            phase_q <= PH_IDLE;
        end else if (load_i) begin
            cells_q <= cell_vec_t'(cells_init_i);
            phase_q <= PH_FILL;
        end else begin
            case (phase_q)
                PH_FILL: begin
                    part_q  <= la_out;
                    phase_q <= PH_RUN;
                end
                PH_RUN: begin
                    cells_q <= {fb, cells_q[NC-1:1]};
                    part_q  <= la_out;
                end
                default: ;
            endcase
        end
    end

    assign cells_o = cells_q;
    assign valid_o = run;

    a_r3_shift_down: assert property (@(posedge clk) disable iff (rst)
        (run && !load_i) |=> cells_q[0] == $past(cells_q[1]));

    a_r5_no_zero_cell: assert property (@(posedge clk) disable iff (rst)
        (run && !load_i) |=> cells_q[NC-1] != '0);

    a_r8_hold_unless_running: assert property (@(posedge clk) disable iff (rst)
        (!run && !load_i) |=> $stable(cells_q));

    a_r6_load_drops_valid: assert property (@(posedge clk) disable iff (rst)
        load_i |=> !valid_o);

    a_r6_valid_after_fill: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_o) |-> $past(phase_q == PH_FILL));
endmodule

// File: tb/sim_zlf_feedback_pipe.sv
module sim_zlf_feedback_pipe;
    localparam int CLK_P = 10;
    localparam longint PM = 64'h7FFF_FFFF;

    logic clk = 0;
    logic rst = 1;
    logic load_i = 0;
    logic init_mode_i = 0;
    logic [31:0] w_i = '0;
    logic [495:0] cells_init_i = '0;
    logic [495:0] cells_o;
    logic valid_o;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] seed = 32'h1234_5678;

    longint m_cells [16];
    int     m_phase = 0;

    zlf_feedback_pipe u0 (
        .clk(clk), .rst(rst), .load_i(load_i), .init_mode_i(init_mode_i),
        .w_i(w_i), .cells_init_i(cells_init_i), .cells_o(cells_o), .valid_o(valid_o)
    );

    always #(CLK_P/2) clk = ~clk;

    initial for (int i = 0; i < 16; i++) m_cells[i] = 0;

    // Behavioural reference: integer arithmetic modulo p
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) m_cells[i] = 0;
            m_phase = 0;
        end else if (load_i) begin
            for (int i = 0; i < 16; i++) m_cells[i] = longint'(cells_init_i[31*i +: 31]);
            m_phase = 1;
        end else if (m_phase == 1) begin
            m_phase = 2;
        end else if (m_phase == 2) begin
            longint f;
            longint x3;
            longint u;
            f = (m_cells[15] << 15) + (m_cells[13] << 17) + (m_cells[10] << 21)
              + (m_cells[4] << 20) + m_cells[0] * 257;
            if (init_mode_i) begin
                x3 = ((m_cells[2] & 64'hFFFF) << 16) | (m_cells[0] >> 15);
                u  = ((longint'(w_i) ^ x3) >> 1) & PM;
                f  = f + u;
            end
            f = f % PM;
            if (f == 0) f = PM;
            for (int i = 0; i < 15; i++) m_cells[i] = m_cells[i+1];
            m_cells[15] = f;
        end
    end

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed ^ (seed >> 13);
    endfunction

    task automatic tick(input string tag);
        @(negedge clk);
        n_vec++;
        for (int i = 0; i < 16; i++) begin
            if (longint'(cells_o[31*i +: 31]) != m_cells[i]) begin
                n_bad++;
                $display("FAIL %s cell%0d actual=%h expected=%h", tag, i,
                         cells_o[31*i +: 31], m_cells[i][30:0]);
                break;
            end
        end
        if (valid_o != (m_phase == 2)) begin
            n_bad++;
            $display("FAIL R6 valid actual=%0b expected=%0b", valid_o, m_phase == 2);
        end
    endtask

    task automatic load_vec(input logic [495:0] v, input string tag);
        cells_init_i = v;
        load_i = 1;
        tick(tag);
        load_i = 0;
        tick("R6");
    endtask

    function automatic logic [495:0] rnd_cells();
        logic [495:0] v;
        for (int i = 0; i < 16; i++) v[31*i +: 31] = rnd()[30:0];
        return v;
    endfunction

    initial begin
        #(CLK_P*200000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) tick("R1");
        rst = 0;
        // R8: mode and word toggled while idle
        for (int i = 0; i < 4; i++) begin
            init_mode_i = i[0];
            w_i = rnd();
            tick("R8");
        end

        // R2 then R4: 32 initialization steps, then R3 working steps
        init_mode_i = 1;
        w_i = rnd();
        load_vec(rnd_cells(), "R2");
        for (int i = 0; i < 32; i++) begin
            w_i = rnd();
            tick("R4");
        end
        init_mode_i = 0;
        for (int i = 0; i < 40; i++) tick("R3");

        // R5: all-zero state gives a zero residue
        load_vec('0, "R2");
        tick("R5");
        for (int i = 0; i < 10; i++) tick("R3");

        // R7: cells holding 2^31-1
        init_mode_i = 1;
        w_i = '1;
        load_vec({16{31'h7FFF_FFFF}}, "R2");
        for (int i = 0; i < 20; i++) tick("R7");

        // R2/R6: reload while running, held for two edges
        init_mode_i = 0;
        cells_init_i = rnd_cells();
        load_i = 1;
        tick("R2");
        cells_init_i = rnd_cells();
        tick("R2");
        load_i = 0;
        init_mode_i = 1;
        w_i = rnd();
        tick("R8");
        for (int i = 0; i < 12; i++) begin
            w_i = rnd();
            tick("R4");
        end
        init_mode_i = 0;
        for (int i = 0; i < 12; i++) tick("R3");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule